// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block collects a vector of interrupt source lines and turns them into two request lines for a processor: a normal request and a fast request. Each request has its own bank of configuration, so one source line can be routed to the normal path, to the fast path, or to both, with a separate sense type on each side. The source lines pass through a synchroniser first. Each bank then decides per line whether it is pending. A line may be level sensitive (active high), or edge sensitive on a rising or falling edge. An edge-sensitive line holds its pending state until software acknowledges it.

Software reaches the block through a plain synchronous register port: a word address, a write enable and write data. Writes take effect on the clock edge. Read data is a combinational function of the address. The normal bank occupies word offsets 0x00 to 0x14 and the fast bank occupies the same layout at 0x20 to 0x34. A handler reads the status word, services the lowest set bit, acknowledges edge lines and reads again until the word is zero.

Top module: `dual_bank_intc`

## Requirements
- R1: After a synchronous active-low reset, every enable, sense-type and edge-latch bit in both banks is zero, and both request outputs are low.
- R2: Reading offset 0x00 (normal bank) or 0x20 (fast bank) returns the source lines after a two-flop synchroniser, one bit per line.
- R3: The enable register (0x04 normal, 0x24 fast) is readable and writable. Bit n = 1 lets line n reach status. The status word (0x14 / 0x34) equals the pending bits ANDed with the enable bits.
- R4: A line whose type bit (0x0C / 0x2C) is 0 is level sensitive and active high: it is pending exactly while its synchronised input is 1, and its edge-select bit (0x10 / 0x30) has no effect.
- R5: Type bit 1 with edge-select bit 1 latches the line as pending on a 0-to-1 transition of the synchronised input. The latch stays set after the input returns low.
- R6: Type bit 1 with edge-select bit 0 latches on a 1-to-0 transition, and a 0-to-1 transition does not latch.
- R7: Writing the acknowledge register (0x08 / 0x28) clears the latch of every line whose data bit is 1. Bits written as 0 leave their latches unchanged. The acknowledge register reads as zero.
- R8: When an edge is detected in the same cycle as an acknowledge of that line, the line stays pending.
- R9: Each request output is the OR of its bank's status bits, delayed by one register stage.
- R10: The two banks are independent: enabling or configuring a line in one bank does not change status or the request of the other bank.
- R11: Addresses outside the twelve defined word offsets (any offset with address bits above bit 5 set, word indices 6 and 7 of a bank, or a non-word-aligned address) read as zero, and writes to them change no state.
- R12: Writes to the source and status offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lines_i | input | LINES (32) | Asynchronous interrupt source lines |
| bus_addr_i | input | ADDR_W (8) | Byte address of the register access |
| bus_we_i | input | 1 | Write enable, sampled on the clock edge |
| bus_wdata_i | input | LINES (32) | Write data |
| bus_rdata_o | output | LINES (32) | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Registered normal-bank request |
| fiq_o | output | 1 | Registered fast-bank request |

## Verification
The sense logic is tested with input sequences on one line. A high-then-low level separates level following from latching. A rising pulse under rising and under falling configuration separates the two edge polarities. A falling step then confirms that falling detection works. Acknowledge writes with the target bit 0 and then 1 separate true write-one-to-clear from any write clearing the latch, and an edge aligned to the same cycle as an acknowledge shows which of the two wins. A line enabled only in the fast bank shows that the banks do not share state. Writes to aliased and read-only addresses show that the decoder does not fold those addresses onto live registers.

// File: rtl/intc_pkg.sv
// Package: shared types for the dual-bank interrupt controller.
// Assumes word-aligned register offsets, with eight word slots per bank.
package intc_pkg;

    // Word index of a register inside one bank (address bits [4:2]).
    typedef enum logic [2:0] {
        IDX_SRC  = 3'd0,
        IDX_EN   = 3'd1,
        IDX_ACK  = 3'd2,
        IDX_TYPE = 3'd3,
        IDX_EDGE = 3'd4,
        IDX_STAT = 3'd5
    } reg_idx_e;

    // Per-bank write strobes produced by the decoder.
    typedef struct packed {
        logic en;
        logic ack;
        logic typ;
        logic edg;
    } bank_wr_t;

    localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/intc_sync.sv
// Module: intc_sync
// Multi-flop synchroniser for a vector of asynchronous level signals.
// Assumes each bit is independent; no bus coherency is provided.
module intc_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/intc_bank.sv
// Module: intc_bank
// One interrupt bank: enable, sense type, edge select, edge latches,
// masked status and a registered request output.
// Assumes lvl_i is synchronous and lvl_prev_i is lvl_i delayed one cycle.
module intc_bank
    import intc_pkg::*;
#(
    parameter int unsigned LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl_i,
    input  logic [LINES-1:0] lvl_prev_i,
    input  bank_wr_t         wr_i,
    input  logic [LINES-1:0] wdata_i,
    output logic [LINES-1:0] en_o,
    output logic [LINES-1:0] type_o,
    output logic [LINES-1:0] edge_o,
    output logic [LINES-1:0] stat_o,
    output logic             req_o
);

    logic [LINES-1:0] en_q, type_q, edge_q, latch_q;
    logic [LINES-1:0] rise, fall, edge_hit, ack_vec, latch_d, pending;
    logic             req_q;

    // Detect the configured edge on each edge-sensitive line.
    always_comb begin
        rise     = lvl_i & ~lvl_prev_i;
        fall     = ~lvl_i & lvl_prev_i;
        edge_hit = type_q & ((edge_q & rise) | (~edge_q & fall));
    end

    // Acknowledge clears set bits, a new edge wins, level lines keep no latch.
    always_comb begin
        ack_vec = wr_i.ack ? wdata_i : '0;
        latch_d = ((latch_q & ~ack_vec) | edge_hit) & type_q;
    end

    // Level lines follow the input, edge lines use the latch.
    always_comb begin
        pending = (type_q & latch_q) | (~type_q & lvl_i);
        stat_o  = pending & en_q;
    end

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            type_q <= '0;
            edge_q <= '0;
        end else begin
            if (wr_i.en)  en_q   <= wdata_i;
            if (wr_i.typ) type_q <= wdata_i;
            if (wr_i.edg) edge_q <= wdata_i;
        end
    end

    // Sticky edge latches.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end

    // Registered request towards the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |stat_o;
    end

    assign en_o   = en_q;
    assign type_o = type_q;
    assign edge_o = edge_q;
    assign req_o  = req_q;

    // R1: right after reset the bank is disabled, level sensitive and quiet.
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && type_q == '0 && latch_q == '0 && !req_q));

    // R9: request equals the OR of status from the previous cycle.
    p_req_tracks_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req_o == $past(|stat_o)));

    // R7: a latch drops only when acknowledged or when its line left edge mode.
    p_latch_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(latch_q) & ~latch_q) & $past(type_q) & ~$past(ack_vec)) == '0));

    // R8 (and R5, R6): every detected edge is latched, even against an acknowledge.
    p_edge_sets_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & $past(edge_hit)) == $past(edge_hit)));

endmodule

// File: rtl/intc_regif.sv
// Module: intc_regif
// Address decoder and read multiplexer for both banks.
// Assumes byte addresses, word registers, and bank select on address bit 5.
module intc_regif
    import intc_pkg::*;
#(
    parameter int unsigned LINES  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic                            we_i,
    input  logic [LINES-1:0]                src_i,
    input  logic [NUM_BANKS-1:0][LINES-1:0] en_i,
    input  logic [NUM_BANKS-1:0][LINES-1:0] type_i,
    input  logic [NUM_BANKS-1:0][LINES-1:0] edge_i,
    input  logic [NUM_BANKS-1:0][LINES-1:0] stat_i,
    output bank_wr_t [NUM_BANKS-1:0]        wr_o,
    output logic [LINES-1:0]                rdata_o
);

    localparam int unsigned BANK_BIT = 5;

    reg_idx_e idx;
    logic     bank_sel;
    logic     hit;

    // Split the address and flag accesses to defined registers.
    always_comb begin
        idx      = reg_idx_e'(addr_i[4:2]);
        bank_sel = addr_i[BANK_BIT];
        hit      = (addr_i[1:0] == 2'b00) && (addr_i[4:2] <= 3'd5);
        if (ADDR_W > BANK_BIT + 1) begin
            if (addr_i >> (BANK_BIT + 1) != '0) hit = 1'b0;
        end
    end

    // Write strobes per bank; source and status are not writable.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wr
        logic sel;
        assign sel          = we_i && hit && (bank_sel == 1'(b));
        assign wr_o[b].en   = sel && (idx == IDX_EN);
        assign wr_o[b].ack  = sel && (idx == IDX_ACK);
        assign wr_o[b].typ  = sel && (idx == IDX_TYPE);
        assign wr_o[b].edg  = sel && (idx == IDX_EDGE);
    end

    // Read multiplexer; acknowledge and unmapped slots return zero.
    always_comb begin
        rdata_o = '0;
        if (hit) begin
            unique case (idx)
                IDX_SRC:  rdata_o = src_i;
                IDX_EN:   rdata_o = en_i[bank_sel];
                IDX_TYPE: rdata_o = type_i[bank_sel];
                IDX_EDGE: rdata_o = edge_i[bank_sel];
                IDX_STAT: rdata_o = stat_i[bank_sel];
                default:  rdata_o = '0;
            endcase
        end
    end

    // R11: an access outside the map reads zero and strobes nothing.
    p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (rdata_o == '0 && wr_o == '0));

endmodule

// File: rtl/dual_bank_intc.sv
// Module: dual_bank_intc
// Top level: synchronises the source lines and feeds two independent
// interrupt banks behind one register port.
// Assumes a single clock domain for the bus and both request outputs.
module dual_bank_intc
    import intc_pkg::*;
#(
    parameter int unsigned LINES       = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  src_lines_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [LINES-1:0]  bus_wdata_i,
    output logic [LINES-1:0]  bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);

    logic [LINES-1:0]                src_sync, src_prev;
    logic [NUM_BANKS-1:0][LINES-1:0] en_s, type_s, edge_s, stat_s;
    logic [NUM_BANKS-1:0]            req_s;
    bank_wr_t [NUM_BANKS-1:0]        wr_s;

    intc_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_lines_i),
        .sync_o  (src_sync)
    );

    // One-cycle history of the synchronised lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_prev <= '0;
        else        src_prev <= src_sync;
    end

    intc_regif #(.LINES(LINES), .ADDR_W(ADDR_W)) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr_i),
        .we_i    (bus_we_i),
        .src_i   (src_sync),
        .en_i    (en_s),
        .type_i  (type_s),
        .edge_i  (edge_s),
        .stat_i  (stat_s),
        .wr_o    (wr_s),
        .rdata_o (bus_rdata_o)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        intc_bank #(.LINES(LINES)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl_i      (src_sync),
            .lvl_prev_i (src_prev),
            .wr_i       (wr_s[b]),
            .wdata_i    (bus_wdata_i),
            .en_o       (en_s[b]),
            .type_o     (type_s[b]),
            .edge_o     (edge_s[b]),
            .stat_o     (stat_s[b]),
            .req_o      (req_s[b])
        );
    end

    assign irq_o = req_s[0];
    assign fiq_o = req_s[1];

    // R10: a bank's request never rises while that bank had no status.
    p_bank_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_s[1] == '0) |=> !fiq_o);

endmodule

// File: tb/tb_dual_bank_intc.sv
module tb_dual_bank_intc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    dual_bank_intc dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_lines_i (src),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wd),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .fiq_o       (fiq)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] src;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        eirq;
        logic        efiq;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  32'h0, 1'b0, 8'h04, 32'h0, 32'h0, 1'b0, 1'b0},               // R1 enable zero
        '{4'd2,  32'h1, 1'b0, 8'h00, 32'h0, 32'h1, 1'b0, 1'b0},               // R2 source
        '{4'd3,  32'h1, 1'b0, 8'h14, 32'h0, 32'h0, 1'b0, 1'b0},               // R3 masked
        '{4'd3,  32'h1, 1'b1, 8'h04, 32'h3, 32'h3, 1'b1, 1'b0},               // R3 enable
        '{4'd4,  32'h1, 1'b0, 8'h14, 32'h0, 32'h1, 1'b1, 1'b0},               // R4 level high
        '{4'd4,  32'h0, 1'b0, 8'h14, 32'h0, 32'h0, 1'b0, 1'b0},               // R4 level low
        '{4'd4,  32'h1, 1'b1, 8'h10, 32'h1, 32'h1, 1'b1, 1'b0},               // R4 select ignored
        '{4'd4,  32'h0, 1'b1, 8'h10, 32'h0, 32'h0, 1'b0, 1'b0},
        '{4'd5,  32'h0, 1'b1, 8'h0C, 32'h2, 32'h2, 1'b0, 1'b0},
        '{4'd5,  32'h0, 1'b1, 8'h10, 32'h2, 32'h2, 1'b0, 1'b0},
        '{4'd5,  32'h2, 1'b0, 8'h14, 32'h0, 32'h2, 1'b1, 1'b0},               // R5 rise
        '{4'd5,  32'h0, 1'b0, 8'h14, 32'h0, 32'h2, 1'b1, 1'b0},               // R5 sticky
        '{4'd7,  32'h0, 1'b1, 8'h08, 32'h1, 32'h0, 1'b1, 1'b0},               // R7 zero bit
        '{4'd7,  32'h0, 1'b1, 8'h08, 32'h2, 32'h0, 1'b0, 1'b0},               // R7 one bit
        '{4'd7,  32'h0, 1'b0, 8'h14, 32'h0, 32'h0, 1'b0, 1'b0},
        '{4'd6,  32'h0, 1'b1, 8'h10, 32'h0, 32'h0, 1'b0, 1'b0},
        '{4'd6,  32'h2, 1'b0, 8'h14, 32'h0, 32'h0, 1'b0, 1'b0},               // R6 rise ignored
        '{4'd6,  32'h0, 1'b0, 8'h14, 32'h0, 32'h2, 1'b1, 1'b0},               // R6 fall
        '{4'd7,  32'h0, 1'b1, 8'h08, 32'h2, 32'h0, 1'b0, 1'b0},
        '{4'd10, 32'h0, 1'b1, 8'h24, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0},
        '{4'd10, 32'h8000_0000, 1'b0, 8'h34, 32'h0, 32'h8000_0000, 1'b0, 1'b1}, // R10 fast only
        '{4'd10, 32'h8000_0000, 1'b0, 8'h14, 32'h0, 32'h0, 1'b0, 1'b1},       // R10 normal quiet
        '{4'd2,  32'h0, 1'b0, 8'h20, 32'h0, 32'h0, 1'b0, 1'b0},
        '{4'd11, 32'h0, 1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0},       // R11 slot 6
        '{4'd11, 32'h0, 1'b0, 8'h04, 32'h0, 32'h3, 1'b0, 1'b0},
        '{4'd11, 32'h0, 1'b1, 8'h44, 32'h0, 32'h0, 1'b0, 1'b0},               // R11 alias
        '{4'd11, 32'h0, 1'b0, 8'h04, 32'h0, 32'h3, 1'b0, 1'b0},
        '{4'd12, 32'h0, 1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0},       // R12 status
        '{4'd12, 32'h0, 1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0}        // R12 source
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk); addr = a; wd = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        nvec++; nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        addr = 8'h0C; #0; chk("R1 type reg", rdata, 32'h0);
        addr = 8'h24; #0; chk("R1 fast enable", rdata, 32'h0);
        chk("R1 requests", {30'h0, irq, fiq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            src = VEC[i].src; addr = VEC[i].addr; wd = VEC[i].wd; we = VEC[i].wr;
            @(negedge clk); we = 1'b0;
            repeat (4) @(negedge clk);
            chk($sformatf("R%0d vec%0d rdata", VEC[i].req, i), rdata, VEC[i].exp);
            chk($sformatf("R%0d vec%0d irq", VEC[i].req, i), {31'h0, irq}, {31'h0, VEC[i].eirq});
            chk($sformatf("R%0d vec%0d fiq", VEC[i].req, i), {31'h0, fiq}, {31'h0, VEC[i].efiq});
        end

        // R8: an edge in the same cycle as its acknowledge stays pending.
        bus_write(8'h10, 32'h2);          // line 1 rising
        @(negedge clk); src = 32'h2; settle();
        chk("R8 setup latched", {31'h0, irq}, 32'h1);
        @(negedge clk); src = 32'h0; settle();
        @(negedge clk); src = 32'h2;      // rise detected between edges 2 and 3
        @(negedge clk);
        @(negedge clk); addr = 8'h08; wd = 32'h2; we = 1'b1;
        @(negedge clk); we = 1'b0; addr = 8'h14;
        repeat (4) @(negedge clk);
        chk("R8 edge beats acknowledge", rdata, 32'h2);
        bus_write(8'h08, 32'h2);
        addr = 8'h14; settle();
        chk("R7 acknowledge alone clears", rdata, 32'h0);

        // R9: request follows status one register later (line 0 level).
        @(negedge clk); src = 32'h0; addr = 8'h14; settle();
        src = 32'h3;
        @(negedge clk);
        @(negedge clk);
        chk("R9 status visible", rdata & 32'h1, 32'h1);
        chk("R9 request not yet", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 request one later", {31'h0, irq}, 32'h1);

        // R1: reset in the middle of a run.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; src = 32'h0;
        addr = 8'h04; #0; chk("R1 enable after reset", rdata, 32'h0);
        addr = 8'h10; #0; chk("R1 edge select after reset", rdata, 32'h0);
        chk("R1 request after reset", {31'h0, irq}, 32'h0);

        finish_run();
    end

endmodule